// File: doc/BRIEF.md
# Burst Bus Master with Slave Wait States

This block is a clocked master on one shared bus. A local client asks it to move a block of one to sixteen words, either to or from a slave. The request gives the direction, a start address and a word count. The master raises its bus request and waits for the arbiter's grant. It then spends exactly one bus cycle on a command phase that carries the direction and the start address. After that it moves the data words one after another on separate data lines. No further address is sent during the burst. The slave paces the burst with a ready line, and each cycle in which ready is low is a wait cycle.

Before a write burst, the client loads the words into a local word buffer through a fill port, indexed from zero. During a read burst, each word the slave returns is handed back to the client one cycle after it was taken, together with its position in the block. The master keeps its request raised until the final word has moved. It then drops the request and pulses a completion flag. While a burst is in progress, the master refuses new requests and buffer fills. It signals this with a busy flag and does not queue them.

Top module: `bm_burst_master`

## Requirements
- R1: After a start is accepted, `bus_req` is high in the next cycle. `bus_cmd` rises only in the cycle right after a cycle in which `bus_grant` was sampled high while the master was requesting.
- R2: The command cycle lasts one cycle. In it, `bus_addr` is the start address and `bus_write` is the direction (1 = write, 0 = read). In every other cycle, `bus_addr` is zero.
- R3: In a data-phase cycle with `bus_ready` low, no word moves. The word on `bus_wdata` in the following cycle is unchanged.
- R4: One word moves in each data-phase cycle in which `bus_ready` is high. A burst moves exactly `cl_len` words. Write words leave in buffer order, from index 0 upward.
- R5: For each read word taken, `rd_valid` is high in the next cycle. In that cycle, `rd_data` holds the word sampled from `bus_rdata`, and `rd_idx` holds its position in the block.
- R6: `bus_req` stays high through the command and data phases. It falls in the cycle after the last word moves.
- R7: `cl_done` is high for exactly one cycle per burst, in the cycle after the last word moves.
- R8: `cl_busy` is high from the cycle after an accepted start until the cycle after the last word. A start that arrives while busy is ignored and causes no further bus activity.
- R9: A start whose `cl_len` is 0 or greater than 16 is refused. It raises neither `bus_req` nor `cl_busy`.
- R10: A buffer fill (`wb_we`) made while busy is ignored. The buffer keeps its earlier content for the current burst and for later bursts.
- R11: During and after reset, `bus_req`, `bus_cmd`, `bus_dphase`, `cl_busy` and `cl_done` are low.
- R12: `bus_wdata` is zero, which stands for undriven, except while `bus_wen` is high. `bus_wen` is high only in the data phase of a write burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cl_start | input | 1 | Client request strobe |
| cl_write | input | 1 | Direction of the request, 1 = write |
| cl_addr | input | AW | Start address of the block |
| cl_len | input | LW | Word count, valid range 1..MAX_LEN |
| cl_busy | output | 1 | Burst in progress, new requests refused |
| cl_done | output | 1 | One-cycle pulse after the final word |
| wb_we | input | 1 | Write strobe into the word buffer |
| wb_idx | input | IW | Word buffer index |
| wb_data | input | DW | Word to store in the buffer |
| rd_valid | output | 1 | Read word returned to the client |
| rd_idx | output | IW | Position of the returned word in the block |
| rd_data | output | DW | Returned read word |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_cmd | output | 1 | Command and address phase marker |
| bus_write | output | 1 | Transfer direction during command and data phases |
| bus_addr | output | AW | Start address, non-zero only in the command cycle |
| bus_dphase | output | 1 | Data phase in progress |
| bus_wen | output | 1 | Master is driving the data lines |
| bus_wdata | output | DW | Write data lines |
| bus_rdata | input | DW | Read data lines from the slave |
| bus_ready | input | 1 | Slave ready; a word moves when high in the data phase |

## Verification
The assertions take for granted that the arbiter holds `bus_grant` while `bus_req` stays high, and that the slave changes `bus_ready` and `bus_rdata` only between clock edges. The bench's slave model raises grant after a random delay of zero to three cycles and keeps it until the request falls. It chooses ready at random in each data cycle, which yields runs of wait cycles, and drives a read word computed from the start address and the beat number. Random bursts of random length and direction are mixed with directed ones: the minimum and maximum lengths, both illegal lengths, a start issued while busy, and a buffer fill issued while busy.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CMD  = 2'd2,
    ST_DATA = 2'd3
  } bm_state_t;
endpackage

// File: rtl/bm_wbuf.sv
module bm_wbuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bm_seq.sv
module bm_seq
  import bm_pkg::*;
#(
  parameter int AW      = 16,
  parameter int MAX_LEN = 16,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int IW     = $clog2(MAX_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          write,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] len,
  input  logic          grant,
  input  logic          ready,
  output logic          busy,
  output logic          done,
  output logic          beat,
  output logic [IW-1:0] cnt,
  output logic [IW-1:0] raddr,
  output logic          bus_req,
  output logic          bus_cmd,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic          bus_dphase,
  output logic          bus_wen
);
  bm_state_t     state;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic          len_ok;
  logic          last;

  assign len_ok = (len != '0) && (len <= LW'(MAX_LEN));
  assign last   = (LW'(cnt) == len_q - LW'(1));
  assign beat   = (state == ST_DATA) && ready;
  assign busy   = (state != ST_IDLE);

  // prefetch address: the buffer output must show the next word right after a beat
  always_comb begin
    if (state == ST_DATA) raddr = beat ? cnt + IW'(1) : cnt;
    else                  raddr = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      wr_q       <= 1'b0;
      addr_q     <= '0;
      len_q      <= '0;
      cnt        <= '0;
      done       <= 1'b0;
      bus_req    <= 1'b0;
      bus_cmd    <= 1'b0;
      bus_write  <= 1'b0;
      bus_addr   <= '0;
      bus_dphase <= 1'b0;
      bus_wen    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start && len_ok) begin
            state   <= ST_REQ;
            bus_req <= 1'b1;
            wr_q    <= write;
            addr_q  <= addr;
            len_q   <= len;
            cnt     <= '0;
          end
        end
        ST_REQ: begin
          if (grant) begin
            state     <= ST_CMD;
            bus_cmd   <= 1'b1;
            bus_addr  <= addr_q;
            bus_write <= wr_q;
          end
        end
        ST_CMD: begin
          state      <= ST_DATA;
          bus_cmd    <= 1'b0;
          bus_addr   <= '0;
          bus_dphase <= 1'b1;
          bus_wen    <= wr_q;
        end
        ST_DATA: begin
          if (ready) begin
            if (last) begin
              state      <= ST_IDLE;
              bus_req    <= 1'b0;
              bus_dphase <= 1'b0;
              bus_wen    <= 1'b0;
              bus_write  <= 1'b0;
              done       <= 1'b1;
            end else begin
              cnt <= cnt + IW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: command phase only follows a sampled grant
  a_r1_cmd_after_grant: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_cmd) |-> $past(grant && bus_req));

  // R2: address lines carry a value only in the command cycle
  a_r2_addr_only_in_cmd: assert property (@(posedge clk) disable iff (rst)
    !bus_cmd |-> bus_addr == '0);

  // R2: command phase is a single cycle followed by the data phase
  a_r2_cmd_one_cycle: assert property (@(posedge clk) disable iff (rst)
    bus_cmd |=> !bus_cmd && bus_dphase);

  // R6: bus is held for the whole data phase
  a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd || bus_dphase) |-> bus_req);

  // R7: completion pulse follows a beat that ended the data phase
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(bus_dphase && ready) && !bus_dphase);

  // R12: data lines driven only in a write data phase
  a_r12_wen_in_write: assert property (@(posedge clk) disable iff (rst)
    bus_wen |-> bus_dphase && bus_write);
endmodule

// File: rtl/bm_burst_master.sv
module bm_burst_master #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int MAX_LEN = 16,
  localparam int LW     = $clog2(MAX_LEN + 1),
  localparam int IW     = $clog2(MAX_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cl_start,
  input  logic          cl_write,
  input  logic [AW-1:0] cl_addr,
  input  logic [LW-1:0] cl_len,
  output logic          cl_busy,
  output logic          cl_done,
  input  logic          wb_we,
  input  logic [IW-1:0] wb_idx,
  input  logic [DW-1:0] wb_data,
  output logic          rd_valid,
  output logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_cmd,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic          bus_dphase,
  output logic          bus_wen,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready
);
  logic          beat;
  logic [IW-1:0] cnt;
  logic [IW-1:0] raddr;
  logic [DW-1:0] buf_q;
  logic          fill_ok;

  bm_seq #(.AW(AW), .MAX_LEN(MAX_LEN)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (cl_start),
    .write      (cl_write),
    .addr       (cl_addr),
    .len        (cl_len),
    .grant      (bus_grant),
    .ready      (bus_ready),
    .busy       (cl_busy),
    .done       (cl_done),
    .beat       (beat),
    .cnt        (cnt),
    .raddr      (raddr),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_dphase (bus_dphase),
    .bus_wen    (bus_wen)
  );

  assign fill_ok = wb_we && !cl_busy;

  bm_wbuf #(.DW(DW), .DEPTH(MAX_LEN)) u_wbuf (
    .clk   (clk),
    .we    (fill_ok),
    .waddr (wb_idx),
    .wdata (wb_data),
    .raddr (raddr),
    .rdata (buf_q)
  );

  assign bus_wdata = bus_wen ? buf_q : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_idx   <= '0;
      rd_data  <= '0;
    end else begin
      rd_valid <= beat && !bus_write;
      if (beat && !bus_write) begin
        rd_idx  <= cnt;
        rd_data <= bus_rdata;
      end
    end
  end

  // R3: a wait cycle leaves the driven word in place
  a_r3_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
    (bus_dphase && bus_wen && !bus_ready) |=> $stable(bus_wdata));

  // R5: returned words only follow a read beat
  a_r5_rd_after_beat: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(bus_dphase && bus_ready && !bus_write));

  // R8: busy covers the whole bus tenure
  a_r8_busy_covers_req: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> cl_busy);
endmodule

// File: tb/bm_burst_master_bench.sv
`timescale 1ns/1ps
module bm_burst_master_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MAXL = 16;
  localparam int LW = $clog2(MAXL + 1);
  localparam int IW = $clog2(MAXL);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cl_start = 1'b0, cl_write = 1'b0;
  logic [AW-1:0] cl_addr = '0;
  logic [LW-1:0] cl_len = '0;
  logic cl_busy, cl_done;
  logic wb_we = 1'b0;
  logic [IW-1:0] wb_idx = '0;
  logic [DW-1:0] wb_data = '0;
  logic rd_valid;
  logic [IW-1:0] rd_idx;
  logic [DW-1:0] rd_data;
  logic bus_req, bus_cmd, bus_write, bus_dphase, bus_wen;
  logic bus_grant = 1'b0, bus_ready = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;

  always #2 clk = ~clk;

  bm_burst_master #(.AW(AW), .DW(DW), .MAX_LEN(MAXL)) u_bm_burst_master (
    .clk(clk), .rst(rst), .cl_start(cl_start), .cl_write(cl_write),
    .cl_addr(cl_addr), .cl_len(cl_len), .cl_busy(cl_busy), .cl_done(cl_done),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data),
    .rd_valid(rd_valid), .rd_idx(rd_idx), .rd_data(rd_data),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_cmd(bus_cmd),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_dphase(bus_dphase),
    .bus_wen(bus_wen), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // bench-side models and per-burst records
  logic [DW-1:0] wmodel [MAXL];
  logic [DW-1:0] got_w  [MAXL];
  logic [DW-1:0] got_r  [MAXL];
  logic [AW-1:0] cmd_addr;
  logic          cmd_write;
  int cmd_seen, beats, rd_cnt, done_count, done_cyc, last_cyc, req_fall_cyc;
  int addr_viol, hold_viol, drive_viol, grant_viol, req_viol, rd_order_viol;
  int gdelay;
  logic grant_prev, req_prev, ready_prev, dph_prev;
  logic [DW-1:0] wdata_prev;

  function automatic logic [DW-1:0] slave_word(input logic [AW-1:0] a, input int i);
    return {a, 16'(i * 37 + 5)} ^ 32'h5A3C_0F96;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_rec();
    cmd_seen = 0; beats = 0; rd_cnt = 0; done_count = 0; done_cyc = -1;
    last_cyc = -1; req_fall_cyc = -1;
    addr_viol = 0; hold_viol = 0; drive_viol = 0; grant_viol = 0;
    req_viol = 0; rd_order_viol = 0;
  endtask

  // slave, arbiter and monitor: sample outputs, then drive inputs for the next edge
  always @(negedge clk) begin
    if (!rst) begin
      if (cl_done) begin done_count++; done_cyc = cyc; end
      if (rd_valid) begin
        if (int'(rd_idx) != rd_cnt) rd_order_viol++;
        got_r[rd_idx] = rd_data;
        rd_cnt++;
      end
      if (bus_cmd) begin
        cmd_seen++; cmd_addr = bus_addr; cmd_write = bus_write;
        if (!grant_prev) grant_viol++;
      end else if (bus_addr != '0) addr_viol++;
      if (!bus_wen && bus_wdata != '0) drive_viol++;
      if (bus_wen && !(bus_dphase && bus_write)) drive_viol++;
      if (dph_prev && !ready_prev && bus_dphase && bus_wdata != wdata_prev) hold_viol++;
      if ((bus_cmd || bus_dphase) && !bus_req) req_viol++;
      if (req_prev && !bus_req && req_fall_cyc < 0) req_fall_cyc = cyc;
      req_prev = bus_req;

      if (bus_req && !bus_grant) begin
        if (gdelay == 0) bus_grant = 1'b1; else gdelay--;
      end else if (!bus_req) begin
        bus_grant = 1'b0;
        gdelay = $urandom_range(0, 3);
      end
      grant_prev = bus_grant && bus_req;

      bus_ready = bus_dphase ? ($urandom_range(0, 99) < 55) : 1'b0;
      bus_rdata = $urandom();
      if (bus_dphase && bus_ready) begin
        if (bus_write) got_w[beats] = bus_wdata;
        else bus_rdata = slave_word(cmd_addr, beats);
        beats++;
        last_cyc = cyc;
      end
      dph_prev = bus_dphase; ready_prev = bus_ready; wdata_prev = bus_wdata;
    end
  end

  task automatic fill(input int idx, input logic [DW-1:0] d);
    @(negedge clk);
    wb_we = 1'b1; wb_idx = IW'(idx); wb_data = d;
    wmodel[idx] = d;
    @(negedge clk);
    wb_we = 1'b0;
  endtask

  // poke: 0 none, 1 second start while busy, 2 buffer fill of index 1 while busy
  task automatic run_burst(input bit wr, input logic [AW-1:0] a, input int len, input int poke);
    int t;
    clear_rec();
    @(negedge clk);
    cl_start = 1'b1; cl_write = wr; cl_addr = a; cl_len = LW'(len);
    @(negedge clk);
    cl_start = 1'b0;
    check(bus_req === 1'b1, "R1 req after start", bus_req, 1);
    check(cl_busy === 1'b1, "R8 busy after start", cl_busy, 1);
    if (poke == 1) begin
      cl_start = 1'b1; cl_write = ~wr; cl_addr = a ^ 16'h0F0F; cl_len = LW'(3);
    end else if (poke == 2) begin
      wb_we = 1'b1; wb_idx = IW'(1); wb_data = ~wmodel[1];
    end
    @(negedge clk);
    cl_start = 1'b0; wb_we = 1'b0;
    t = 0;
    while (done_count == 0 && t < 600) begin @(negedge clk); t++; end
    check(t < 600, "R7 burst completes", t, 0);
    repeat (6) @(negedge clk);
    check(cmd_seen == 1, "R2 one command phase", cmd_seen, 1);
    check(cmd_addr == a, "R2 command address", cmd_addr, a);
    check(cmd_write == wr, "R2 command direction", cmd_write, wr);
    check(grant_viol == 0, "R1 command only after grant", grant_viol, 0);
    check(addr_viol == 0, "R2 address zero outside command", addr_viol, 0);
    check(beats == len, "R4 word count", beats, len);
    if (wr) begin
      for (int i = 0; i < len; i++)
        check(got_w[i] == wmodel[i], "R4 write word order", got_w[i], wmodel[i]);
      check(hold_viol == 0, "R3 word held in wait", hold_viol, 0);
    end else begin
      check(rd_cnt == len, "R5 returned word count", rd_cnt, len);
      check(rd_order_viol == 0, "R5 returned index order", rd_order_viol, 0);
      for (int i = 0; i < len; i++)
        check(got_r[i] == slave_word(a, i), "R5 returned word", got_r[i], slave_word(a, i));
    end
    check(drive_viol == 0, "R12 data lines quiet", drive_viol, 0);
    check(req_viol == 0, "R6 request held", req_viol, 0);
    check(req_fall_cyc == last_cyc + 1, "R6 request falls after last", req_fall_cyc, last_cyc + 1);
    check(done_count == 1, "R7 single done pulse", done_count, 1);
    check(done_cyc == last_cyc + 1, "R7 done timing", done_cyc, last_cyc + 1);
    check(cl_busy === 1'b0 && bus_req === 1'b0, "R8 idle after burst", cl_busy, 0);
  endtask

  task automatic run_refused(input int len);
    clear_rec();
    @(negedge clk);
    cl_start = 1'b1; cl_write = 1'b1; cl_addr = 16'h1234; cl_len = LW'(len);
    @(negedge clk);
    cl_start = 1'b0;
    check(bus_req === 1'b0, "R9 refused length no request", bus_req, 0);
    check(cl_busy === 1'b0, "R9 refused length not busy", cl_busy, 0);
    repeat (5) @(negedge clk);
    check(cmd_seen == 0, "R9 refused length no command", cmd_seen, 0);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    gdelay = 1; grant_prev = 0; req_prev = 0; ready_prev = 0; dph_prev = 0; wdata_prev = '0;
    clear_rec();
    repeat (4) @(negedge clk);
    // R11: reset state
    check(bus_req === 1'b0 && bus_cmd === 1'b0 && bus_dphase === 1'b0,
          "R11 bus idle in reset", bus_req, 0);
    check(cl_busy === 1'b0 && cl_done === 1'b0, "R11 client idle in reset", cl_busy, 0);
    rst = 1'b0;
    @(negedge clk);
    check(bus_req === 1'b0 && cl_busy === 1'b0, "R11 idle after reset", bus_req, 0);

    for (int i = 0; i < MAXL; i++) fill(i, $urandom());

    run_burst(1'b1, 16'h00A0, 1, 0);     // shortest write
    run_burst(1'b0, 16'h0400, 1, 0);     // shortest read
    run_burst(1'b1, 16'hFFF0, MAXL, 0);  // longest write
    run_burst(1'b0, 16'h8000, MAXL, 0);  // longest read
    run_refused(0);                      // R9
    run_refused(MAXL + 1);               // R9
    run_burst(1'b0, 16'h2222, 5, 1);     // R8: start while busy ignored
    run_burst(1'b1, 16'h3330, 4, 2);     // R10: fill while busy ignored
    run_burst(1'b1, 16'h3340, 4, 0);     // R10: buffer still holds earlier content

    for (int n = 0; n < 30; n++) begin
      if ($urandom_range(0, 2) == 0) fill($urandom_range(0, MAXL - 1), $urandom());
      run_burst(1'($urandom_range(0, 1)), 16'($urandom()), $urandom_range(1, MAXL), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule